// File: doc/BRIEF.md
# Window Watchdog Reset Controller

This block supervises a processor through a single trigger input and drives an active-low system reset. It enforces both an upper and a lower bound on trigger timing. When the reset is released, the block opens a long start-up window in which the first trigger may come at any time. After that first trigger it repeats a cycle of two parts. The first part is a closed window in which a trigger is illegal. The second part is an open window in which a trigger is expected. A trigger in the open window starts a new cycle. A trigger in the closed window, or no trigger by the end of the open window, produces a reset pulse of fixed length. When that pulse ends, the block goes back to the start-up window.

Every duration is a parameter counted in cycles of a one-cycle time-base enable `tick`. A test can therefore use a time base of a few clock cycles, and a chip can use a prescaled time base. The trigger passes through a two-flop synchroniser. It then goes to a width qualifier that rejects short glitches. A qualified pulse acts at its trailing edge. An undervoltage flag input keeps the reset asserted while it is high, and for an extra hold time after it falls.

Top module: `wwdg_reset_ctl`

## Requirements
- R1: While `rst` is high, `phase` is 3 and `sys_rst_n` is 0. After `rst` falls, the reset lasts a further UV_HOLD_TICKS ticks, and then `phase` becomes 0.
- R2: In the start-up window (`phase` 0), a valid trigger moves the block to the closed window. If no valid trigger arrives within INIT_TICKS ticks, the block moves to a watchdog reset.
- R3: A trigger pulse is valid only if the synchronised level stays high for at least TRIG_MIN_CYC clock cycles. Shorter pulses have no effect. A valid pulse acts on the third clock edge after `trig` falls.
- R4: A valid trigger in the open window (`phase` 2) starts a new closed window and keeps `sys_rst_n` high.
- R5: A valid trigger in the closed window (`phase` 1) moves the block to the reset phase at once.
- R6: If the open window runs for OPEN_TICKS ticks with no valid trigger, the block moves to the reset phase.
- R7: A watchdog reset holds `sys_rst_n` low for WD_RST_TICKS ticks. After that, the block enters the start-up window.
- R8: On the clock edge after `uv` goes high, the block enters the reset phase. It stays there while `uv` is high, and for UV_HOLD_TICKS ticks after `uv` falls.
- R9: One long trigger pulse counts as exactly one trigger. The closed window it opens runs for its full CLOSED_TICKS ticks.
- R10: Window and pulse timers advance only on cycles where `tick` is high. The closed window lasts CLOSED_TICKS ticks.
- R11: The `phase` output codes are: 0 start-up, 1 closed, 2 open, 3 reset. `sys_rst_n` is 0 exactly when `phase` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; forces the reset phase |
| tick | input | 1 | Time-base enable, one cycle wide |
| trig | input | 1 | Asynchronous trigger from the supervised processor, active high |
| uv | input | 1 | Undervoltage flag, active high |
| sys_rst_n | output | 1 | Active-low system reset |
| phase | output | 2 | Current phase code (see R11) |

## Verification
The phase register drives the reset output directly. A wrong phase or a wrong window count therefore shows up on `phase` on the very next clock edge. It shows up on `sys_rst_n` when a trigger lands, or a window ends, in the wrong place. For example, a window counter that is off by one moves the transition to the next window by exactly one tick. A qualifier that counts too few cycles lets a glitch start a closed window. The effect then shows as a phase change three clock cycles after the glitch ends. The bench measures every window length in clock cycles and places triggers at exact cycles, so both kinds of fault appear on the ports within one window.

// File: rtl/wwdg_reset_ctl.sv
module wwdg_reset_ctl #(
  parameter int INIT_TICKS    = 490,
  parameter int CLOSED_TICKS  = 100,
  parameter int OPEN_TICKS    = 105,
  parameter int WD_RST_TICKS  = 19,
  parameter int UV_HOLD_TICKS = 100,
  parameter int TRIG_MIN_CYC  = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       trig,
  input  logic       uv,
  output logic       sys_rst_n,
  output logic [1:0] phase
);
  localparam int CW = $clog2(INIT_TICKS + CLOSED_TICKS + OPEN_TICKS + WD_RST_TICKS + UV_HOLD_TICKS + 1);
  localparam int WW = $clog2(TRIG_MIN_CYC + 1);
  localparam logic [1:0] PH_INIT = 2'd0, PH_CLOSED = 2'd1, PH_OPEN = 2'd2, PH_RST = 2'd3;

  logic          s1, s2, hit, last;
  logic [WW-1:0] wcnt;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      wcnt <= '0;
    end else begin
      s1 <= trig;
      s2 <= s1;
      if (!s2) wcnt <= '0;
      else if (wcnt != WW'(TRIG_MIN_CYC)) wcnt <= wcnt + 1'b1;
    end
  end

  assign hit  = !s2 && (wcnt == WW'(TRIG_MIN_CYC));
  assign last = tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst || uv) begin
      phase <= PH_RST;
      cnt   <= CW'(UV_HOLD_TICKS);
    end else begin
      case (phase)
        PH_INIT:
          if (hit) begin phase <= PH_CLOSED; cnt <= CW'(CLOSED_TICKS); end
          else if (last) begin phase <= PH_RST; cnt <= CW'(WD_RST_TICKS); end
          else if (tick) cnt <= cnt - 1'b1;
        PH_CLOSED:
          if (hit) begin phase <= PH_RST; cnt <= CW'(WD_RST_TICKS); end
          else if (last) begin phase <= PH_OPEN; cnt <= CW'(OPEN_TICKS); end
          else if (tick) cnt <= cnt - 1'b1;
        PH_OPEN:
          if (hit) begin phase <= PH_CLOSED; cnt <= CW'(CLOSED_TICKS); end
          else if (last) begin phase <= PH_RST; cnt <= CW'(WD_RST_TICKS); end
          else if (tick) cnt <= cnt - 1'b1;
        default:
          if (last) begin phase <= PH_INIT; cnt <= CW'(INIT_TICKS); end
          else if (tick) cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign sys_rst_n = (phase != PH_RST);

  assert_uv_forces_reset_R8: assert property (@(posedge clk) disable iff (rst)
    uv |=> (phase == PH_RST && !sys_rst_n));
  assert_closed_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLOSED && hit && !uv) |=> (phase == PH_RST));
  assert_open_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPEN && hit && !uv) |=> (phase == PH_CLOSED && sys_rst_n));
  assert_open_expire_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPEN && last && !hit && !uv) |=> (phase == PH_RST));
  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hit && !uv) |=> $stable(phase));
endmodule

// File: tb/wwdg_reset_ctl_tb.sv
module wwdg_reset_ctl_tb_top;
  localparam int INIT_T = 16, CLOSED_T = 10, OPEN_T = 10, WD_T = 4, UV_T = 5, TMIN = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, trig = 1'b0, uv = 1'b0;
  logic sys_rst_n;
  logic [1:0] phase;

  typedef struct { logic [1:0] ph; logic rn; string tag; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  wwdg_reset_ctl #(.INIT_TICKS(INIT_T), .CLOSED_TICKS(CLOSED_T), .OPEN_TICKS(OPEN_T),
    .WD_RST_TICKS(WD_T), .UV_HOLD_TICKS(UV_T), .TRIG_MIN_CYC(TMIN)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .trig(trig), .uv(uv),
    .sys_rst_n(sys_rst_n), .phase(phase));

  initial begin : monitor
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      nchk++;
      if (phase !== e.ph || sys_rst_n !== e.rn) begin
        nfail++;
        $display("FAIL %s: phase=%0d rst_n=%b, expected phase=%0d rst_n=%b",
                 e.tag, phase, sys_rst_n, e.ph, e.rn);
      end
    end
  end

  task automatic expect_state(input logic [1:0] ph, input string tag);
    exp_t e;
    e.ph = ph; e.rn = (ph != 2'd3); e.tag = tag;
    q.push_back(e);
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    trig = 1'b1; step(w); trig = 1'b0;
  endtask

  task automatic measure(input logic [1:0] ph, input int expn, input string tag);
    int n = 0;
    while (phase == ph && n < 200) begin @(negedge clk); n++; end
    nchk++;
    if (n != expn) begin
      nfail++;
      $display("FAIL %s: phase %0d lasted %0d cycles, expected %0d", tag, ph, n, expn);
    end
  endtask

  task automatic wait_leave(input logic [1:0] ph);
    int n = 0;
    while (phase == ph && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : driver
    step(3);
    expect_state(2'd3, "R1 reset phase while rst high");
    rst = 1'b0;
    measure(2'd3, UV_T, "R1 reset hold after rst");
    expect_state(2'd0, "R11 start-up code 0");
    measure(2'd0, INIT_T, "R2 start-up window timeout");
    expect_state(2'd3, "R2 timeout gives reset");
    measure(2'd3, WD_T, "R7 watchdog reset length");
    expect_state(2'd0, "R7 back to start-up");

    pulse(TMIN); step(2);
    expect_state(2'd0, "R3 no action before third edge");
    step(1);
    expect_state(2'd1, "R2 min-width trigger enters closed");
    measure(2'd1, CLOSED_T, "R10 closed window length");
    expect_state(2'd2, "R11 open code 2");

    pulse(4); step(3);
    expect_state(2'd1, "R4 open trigger restarts cycle");
    pulse(4); step(3);
    expect_state(2'd3, "R5 closed trigger resets");
    measure(2'd3, WD_T, "R7 reset after early trigger");

    pulse(TMIN - 1); step(3);
    expect_state(2'd0, "R3 glitch ignored");
    step(3);
    expect_state(2'd0, "R3 glitch still ignored");
    measure(2'd0, INIT_T - 8, "R2 start-up window unaffected by glitch");
    wait_leave(2'd3);

    pulse(12); step(3);
    expect_state(2'd1, "R9 long pulse enters closed");
    measure(2'd1, CLOSED_T, "R9 single trigger from long pulse");

    tick = 1'b0; step(20);
    expect_state(2'd2, "R10 open frozen without tick");
    tick = 1'b1;
    measure(2'd2, OPEN_T, "R6 open window expiry");
    expect_state(2'd3, "R6 expiry gives reset");
    wait_leave(2'd3);

    pulse(TMIN); step(3);
    expect_state(2'd1, "R8 setup closed");
    uv = 1'b1; step(1);
    expect_state(2'd3, "R8 uv resets next edge");
    step(8);
    expect_state(2'd3, "R8 held during uv");
    uv = 1'b0;
    measure(2'd3, UV_T, "R8 hold after uv falls");
    expect_state(2'd0, "R8 back to start-up");

    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule